// File: doc/BRIEF.md
# Dual-Mode Vector Post-Add Accumulator

This block is the accumulation stage behind a SIMD multiplier array. Every accepted cycle it takes 128 signed 32-bit products in one packed vector. Adder trees reduce them to per-lane partial sums, and those sums are added into 48-bit accumulator lanes. Each lane carries 16 bits of headroom above the product width, so up to 2^16 products can be summed without overflow.

A mode input sets how the products are grouped. In the eight-lane mode each lane collects sixteen products, and only the low half of the accumulator state is written. In the sixteen-lane mode each lane collects eight products, and both halves are used. The state is presented as two 384-bit halves that together form one 768-bit view. A load control replaces lane contents instead of adding to them. A registered valid flag marks the cycle in which the new contents appear.

Top module: `vec_postadd_acc`

## Requirements
- R1: Lane k (0..15) is 48 bits wide. Lanes 0..7 occupy `acc_lo[48k+47:48k]`, and lane 8+j occupies `acc_hi[48j+47:48j]`.
- R2: Product k (0..127) is taken from `in_prod[32k+31:32k]` as a signed two's-complement value and sign-extended to 48 bits before any addition.
- R3: With `in_wide`=0 (eight-lane mode), lane i (0..7) receives the sum of products 16i..16i+15.
- R4: With `in_wide`=1 (sixteen-lane mode), lane i (0..15) receives the sum of products 8i..8i+7.
- R5: When `in_valid`=1 and `in_load`=1, each written lane is replaced by its sum. When `in_load`=0, the sum is added to the lane's previous contents.
- R6: When `in_valid`=0, all sixteen lanes keep their values and `out_valid` is 0 on the next cycle.
- R7: The new lane contents appear on the clock edge that accepts the input. `out_valid` is 1 for exactly the cycle that follows each accepted input.
- R8: In eight-lane mode, an accepted input leaves `acc_hi` unchanged, whether or not it is a load.
- R9: Accumulation wraps modulo 2^48 and does not saturate.
- R10: A synchronous reset `rst`=1 clears all sixteen lanes and `out_valid` to 0.
- R11: A change of `in_wide` clears nothing. The next accepted input adds into the existing lane contents, which are read in place under the new grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Products present this cycle |
| in_load | input | 1 | 1: replace lane contents, 0: add to them |
| in_wide | input | 1 | 0: eight lanes of sixteen products, 1: sixteen lanes of eight products |
| in_prod | input | 4096 | 128 packed signed 32-bit products |
| out_valid | output | 1 | Lane contents were updated on the last edge |
| acc_lo | output | 384 | Lanes 0..7 |
| acc_hi | output | 384 | Lanes 8..15 |

## Verification
The bench builds the block with its default parameters: 32-bit products, 48-bit lanes, 128 products and groups of eight. These match the two groupings and the 768-bit view exactly. With 48-bit lanes, a run of about 8200 loaded-then-accumulated cycles of full-scale positive products drives the lanes past 2^47 and then past 2^48, so the wrap behaviour is reached within the run. Every cycle is compared against a behavioural model of all sixteen lanes. The stimulus covers random products, extreme negative and positive values, loads, idle cycles, mode switches in both directions and a reset in the middle of a run.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

  // Lane grouping selected at runtime
  typedef enum logic {
    MODE_EIGHT   = 1'b0,
    MODE_SIXTEEN = 1'b1
  } lane_mode_e;

endpackage

// File: rtl/vpa_group_sum.sv
// Reduces GROUP signed products to one ACC_W-bit sum with a heap-indexed adder tree.
module vpa_group_sum #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 48,
  parameter int GROUP  = 8
) (
  input  logic [GROUP*PROD_W-1:0] prods,
  output logic [ACC_W-1:0]        sum
);

  localparam int NODES = 2 * GROUP;

  function automatic logic [ACC_W-1:0] widen(input logic [PROD_W-1:0] p);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  function automatic logic [ACC_W-1:0] add_wrap(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  logic [ACC_W-1:0] node [1:NODES-1];

  for (genvar k = 0; k < GROUP; k++) begin : g_leaf
    assign node[GROUP+k] = widen(prods[k*PROD_W +: PROD_W]);
  end

  for (genvar n = 1; n < GROUP; n++) begin : g_node
    assign node[n] = add_wrap(node[2*n], node[2*n+1]);
  end

  assign sum = node[1];

endmodule

// File: rtl/vpa_lane_route.sv
// Selects each lane's increment and write enable from the group sums and the mode.
module vpa_lane_route
  import vpa_pkg::*;
#(
  parameter int ACC_W     = 48,
  parameter int NUM_LANES = 16
) (
  input  lane_mode_e                 mode,
  input  logic                       valid,
  input  logic [NUM_LANES*ACC_W-1:0] grp_sum,
  output logic [NUM_LANES*ACC_W-1:0] lane_sum,
  output logic [NUM_LANES-1:0]       lane_en
);

  localparam int HALF = NUM_LANES / 2;

  function automatic logic [ACC_W-1:0] pair_add(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  logic [HALF*ACC_W-1:0] pair_sum;

  for (genvar i = 0; i < HALF; i++) begin : g_low
    // eight-lane mode: lane i takes groups 2i and 2i+1 (products 16i..16i+15)
    assign pair_sum[i*ACC_W +: ACC_W] =
      pair_add(grp_sum[(2*i)*ACC_W +: ACC_W], grp_sum[(2*i+1)*ACC_W +: ACC_W]);
    assign lane_sum[i*ACC_W +: ACC_W] = (mode == MODE_SIXTEEN)
                                        ? grp_sum[i*ACC_W +: ACC_W]
                                        : pair_sum[i*ACC_W +: ACC_W];
    assign lane_en[i] = valid;
  end

  for (genvar i = HALF; i < NUM_LANES; i++) begin : g_high
    assign lane_sum[i*ACC_W +: ACC_W] = grp_sum[i*ACC_W +: ACC_W];
    assign lane_en[i] = valid && (mode == MODE_SIXTEEN);
  end

endmodule

// File: rtl/vpa_acc_lane.sv
// One accumulator lane: load or add-wrap on enable, hold otherwise.
module vpa_acc_lane #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [ACC_W-1:0] sum,
  output logic [ACC_W-1:0] q
);

  function automatic logic [ACC_W-1:0] next_val(input logic             ld,
                                                input logic [ACC_W-1:0] cur,
                                                input logic [ACC_W-1:0] inc);
    return ld ? inc : cur + inc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= next_val(load, q, sum);
  end

  // R5: a load replaces the lane contents
  p_load_replace_r5: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> (q == $past(sum)));

  // R9: accumulation adds modulo 2^ACC_W
  p_add_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> (q == $past(q) + $past(sum)));

  // R6: lane holds when not enabled
  p_lane_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

endmodule

// File: rtl/vec_postadd_acc.sv
module vec_postadd_acc
  import vpa_pkg::*;
#(
  parameter int PROD_W    = 32,
  parameter int ACC_W     = 48,
  parameter int NUM_PROD  = 128,
  parameter int GRP_WIDE  = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    in_valid,
  input  logic                                    in_load,
  input  logic                                    in_wide,
  input  logic [NUM_PROD*PROD_W-1:0]              in_prod,
  output logic                                    out_valid,
  output logic [(NUM_PROD/GRP_WIDE/2)*ACC_W-1:0]  acc_lo,
  output logic [(NUM_PROD/GRP_WIDE/2)*ACC_W-1:0]  acc_hi
);

  localparam int NUM_LANES = NUM_PROD / GRP_WIDE;
  localparam int HALF_W    = (NUM_LANES / 2) * ACC_W;
  localparam int GRP_BITS  = GRP_WIDE * PROD_W;

  lane_mode_e                 mode;
  logic [NUM_LANES*ACC_W-1:0] grp_sum;
  logic [NUM_LANES*ACC_W-1:0] lane_sum;
  logic [NUM_LANES-1:0]       lane_en;
  logic [NUM_LANES*ACC_W-1:0] lanes_q;

  assign mode = lane_mode_e'(in_wide);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_grp
    vpa_group_sum #(
      .PROD_W (PROD_W),
      .ACC_W  (ACC_W),
      .GROUP  (GRP_WIDE)
    ) u_sum (
      .prods (in_prod[g*GRP_BITS +: GRP_BITS]),
      .sum   (grp_sum[g*ACC_W +: ACC_W])
    );
  end

  vpa_lane_route #(
    .ACC_W     (ACC_W),
    .NUM_LANES (NUM_LANES)
  ) u_route (
    .mode     (mode),
    .valid    (in_valid),
    .grp_sum  (grp_sum),
    .lane_sum (lane_sum),
    .lane_en  (lane_en)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    vpa_acc_lane #(.ACC_W(ACC_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (lane_en[l]),
      .load (in_load),
      .sum  (lane_sum[l*ACC_W +: ACC_W]),
      .q    (lanes_q[l*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign acc_lo = lanes_q[HALF_W-1:0];
  assign acc_hi = lanes_q[2*HALF_W-1:HALF_W];

  // R6: idle cycles leave the whole 768-bit view unchanged
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc_lo) && $stable(acc_hi) && !out_valid));

  // R8: eight-lane mode never writes the high half
  p_hi_untouched_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wide) |=> $stable(acc_hi));

  // R7: out_valid follows an accepted input by one cycle
  p_out_valid_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

endmodule

// File: tb/test_vec_postadd_acc.sv
module test_vec_postadd_acc;

  localparam int  CLK_PERIOD = 10;
  localparam int  NP   = 128;
  localparam int  NL   = 16;
  localparam longint MASK = (64'sd1 <<< 48) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_load, in_wide;
  logic [4095:0] in_prod;
  logic          out_valid;
  logic [383:0]  acc_lo, acc_hi;

  vec_postadd_acc i_vec_postadd_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_load(in_load),
    .in_wide(in_wide), .in_prod(in_prod), .out_valid(out_valid),
    .acc_lo(acc_lo), .acc_hi(acc_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     prod [NP];
  longint model [NL];
  bit     exp_ov;
  int     n_vec = 0;
  int     n_bad = 0;
  bit     done  = 0;

  function automatic longint dut_lane(int k);
    logic [47:0] s;
    s = (k < 8) ? acc_lo[48*k +: 48] : acc_hi[48*(k-8) +: 48];
    return longint'({16'b0, s});
  endfunction

  task automatic compare(string tag);
    bit bad = 0;
    n_vec++;
    for (int k = 0; k < NL; k++) begin
      if (dut_lane(k) != (model[k] & MASK)) begin
        bad = 1;
        $display("FAIL %s lane %0d: actual %h expected %h", tag, k,
                 dut_lane(k), model[k] & MASK);
      end
    end
    if (out_valid !== exp_ov) begin
      bad = 1;
      $display("FAIL %s out_valid: actual %b expected %b", tag, out_valid, exp_ov);
    end
    if (bad) n_bad++;
  endtask

  task automatic pack();
    for (int k = 0; k < NP; k++) in_prod[32*k +: 32] = prod[k];
  endtask

  // One cycle: drive at negedge, let the edge pass, compare at next negedge
  task automatic apply(bit v, bit ld, bit wd, string tag);
    in_valid = v; in_load = ld; in_wide = wd;
    pack();
    if (v) begin
      int nl = wd ? 16 : 8;
      int gs = wd ? 8 : 16;
      for (int i = 0; i < nl; i++) begin
        longint s = 0;
        for (int j = 0; j < gs; j++) s += longint'(prod[gs*i + j]);
        model[i] = ld ? (s & MASK) : ((model[i] + s) & MASK);
      end
    end
    exp_ov = v;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NL; k++) model[k] = 0;
    exp_ov = 0;
    compare(tag);
  endtask

  task automatic fill_random();
    for (int k = 0; k < NP; k++) prod[k] = int'($urandom);
  endtask

  task automatic fill_const(int v);
    for (int k = 0; k < NP; k++) prod[k] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    in_valid = 0; in_load = 0; in_wide = 0; in_prod = '0;
    fill_const(0);
    @(negedge clk);
    do_reset("R10 initial reset");

    // R2 R3: ramp products, eight-lane load then add
    for (int k = 0; k < NP; k++) prod[k] = k - 64;
    apply(1, 1, 0, "R3 R2 narrow load ramp");
    fill_random();
    apply(1, 0, 0, "R3 R8 narrow accumulate");

    // R4 R1: sixteen-lane load then accumulate random
    fill_random();
    apply(1, 1, 1, "R4 R1 wide load");
    for (int c = 0; c < 5; c++) begin
      fill_random();
      apply(1, 0, 1, "R4 wide accumulate");
    end

    // R6: idle cycles with busy product bus
    for (int c = 0; c < 3; c++) begin
      fill_random();
      apply(0, c[0], c[1], "R6 idle hold");
    end

    // R8: narrow load leaves the high half
    fill_random();
    apply(1, 1, 0, "R8 narrow load keeps high half");

    // R2: extreme values
    fill_const(int'(32'h8000_0000));
    apply(1, 0, 1, "R2 min negative wide");
    fill_const(32'h7FFF_FFFF);
    apply(1, 0, 0, "R2 max positive narrow");

    // R11: mode switches reinterpret in place
    for (int c = 0; c < 6; c++) begin
      fill_random();
      apply(1, 0, c[0], "R11 mode switch");
    end

    // R7: sparse valid pattern
    for (int c = 0; c < 8; c++) begin
      fill_random();
      apply((c % 3) == 0, 0, 1, "R7 sparse valid");
    end

    // R10: reset mid-run
    do_reset("R10 mid-run reset");
    fill_random();
    apply(1, 0, 1, "R5 accumulate from zero");

    // R9: drive lanes past 2^47 and 2^48
    fill_const(32'h7FFF_FFFF);
    apply(1, 1, 0, "R5 load for wrap");
    for (int c = 0; c < 8200; c++) apply(1, 0, 0, "R9 wrap accumulate");

    // R9: negative wrap from zero in wide mode
    fill_const(-1);
    apply(1, 1, 1, "R9 negative load");
    apply(1, 0, 1, "R9 negative accumulate");

    apply(0, 0, 0, "R6 final idle");
    finish_run();
  end

endmodule